// File: doc/BRIEF.md
# Lockable Thermal Protection Controller

This block turns a raw digital reading from an on-die temperature sensor into degrees Celsius and requests a hardware shutdown when the die gets too hot. Firmware sets it up through a small word-addressed register port with an address, a write strobe, write data and combinational read data. It programs a critical limit, a calibration slope and a shutdown enable, and then sets a one-way lock.

The lock covers every control that affects detection or response. It protects the limit, and it also protects the slope that scales the reading and the enable that arms the response. After the lock is set, software cannot hide an overheat by rescaling the sensor or disarming the shutdown. The lock clears only when the block is reset. The shutdown request is sticky, so a short overheat stays visible until reset.

Top module: `thermguard`

## Requirements
- R1: The limit register is at word address 0x0 and holds 8 bits in [7:0]. It resets to 125.
- R2: The slope register is at word address 0x1 and holds 32 bits. It resets to 25.
- R3: The lock register is at word address 0x3 and uses bit [0]. It resets to 0. Writing a 1 sets it. Writing a 0 has no effect. Only reset clears it.
- R4: The control register is at word address 0x2. Its bit [1] is the shutdown enable and resets to 0.
- R5: The current temperature is read at word address 0x4 in bits [7:0] and resets to 0. It is registered: the value read in cycle n+1 comes from the raw reading sampled at the clock edge that ends cycle n.
- R6: Every bit not named in R1 to R5 reads as 0, and writes to those bits are ignored.
- R7: While the lock is 1, writes to the limit, slope and control registers leave their contents unchanged.
- R8: The shutdown output rises one clock after a cycle in which the registered temperature is strictly greater than the limit and the enable is 1. It never rises in any other case.
- R9: Once the shutdown output is 1, it stays 1 until reset.
- R10: The calibrated temperature is (raw × slope) >> 4.
- R11: The calibrated temperature saturates at 255 when the shifted product does not fit in 8 bits.
- R12: Writes to the temperature register or to an unmapped address change nothing. Reads of unmapped addresses (0x5 to 0xF) return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 4 | Word address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| sensor_raw | input | 10 | Raw sensor reading |
| shutdown_req | output | 1 | Sticky hardware shutdown request |

## Verification
A corrupted control register shows up on the read port as soon as it is read back. If the lock is leaky, a locked register changes value on the next read after a write. A fault in the scaling or saturation path appears at the temperature address one cycle after a new raw value. A shutdown that fires early or late differs from the bench's expected value within one cycle. A shutdown that drops is caught on the very next cycle, because the output is compared every cycle.

// File: rtl/thermguard_pkg.sv
package thermguard_pkg;

    localparam int SLOPE_W   = 32;
    localparam int TEMP_W    = 8;

    localparam int ADR_LIMIT = 0;
    localparam int ADR_SLOPE = 1;
    localparam int ADR_CTRL  = 2;
    localparam int ADR_LOCK  = 3;
    localparam int ADR_TEMP  = 4;

    localparam int EN_BIT    = 1;
    localparam int LOCK_BIT  = 0;

    localparam logic [TEMP_W-1:0]  LIMIT_RST = 8'd125;
    localparam logic [SLOPE_W-1:0] SLOPE_RST = 32'd25;

    typedef struct packed {
        logic [TEMP_W-1:0]  limit;
        logic [SLOPE_W-1:0] slope;
        logic               en;
        logic               lock;
    } cfg_t;

    typedef struct packed {
        logic [TEMP_W-1:0] temp;
        logic              shut;
    } det_t;

endpackage

// File: rtl/thermguard_calib.sv
module thermguard_calib #(
    parameter int RAW_W   = 10,
    parameter int SLOPE_W = 32,
    parameter int FRAC_W  = 4,
    parameter int OUT_W   = 8
) (
    input  logic [RAW_W-1:0]   raw,
    input  logic [SLOPE_W-1:0] slope,
    output logic [OUT_W-1:0]   celsius
);
    localparam int PROD_W = RAW_W + SLOPE_W;

    logic [PROD_W-1:0] prod;
    logic [PROD_W-1:0] scaled;
    logic              over;

    always_comb begin
        prod   = PROD_W'(raw) * PROD_W'(slope);
        scaled = prod >> FRAC_W;
        over   = |scaled[PROD_W-1:OUT_W];
        if (over) begin
            celsius = {OUT_W{1'b1}};
        end else begin
            celsius = scaled[OUT_W-1:0];
        end
    end
endmodule

// File: rtl/thermguard_regs.sv
module thermguard_regs
    import thermguard_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic [DATA_W-1:0] wdata,
    output cfg_t              cfg
);
    cfg_t cfg_d, cfg_q;
    logic hit_limit, hit_slope, hit_ctrl, hit_lock;

    always_comb begin
        hit_limit = wr && (addr == ADDR_W'(ADR_LIMIT));
        hit_slope = wr && (addr == ADDR_W'(ADR_SLOPE));
        hit_ctrl  = wr && (addr == ADDR_W'(ADR_CTRL));
        hit_lock  = wr && (addr == ADDR_W'(ADR_LOCK));

        cfg_d = cfg_q;
        if (!cfg_q.lock) begin
            if (hit_limit) cfg_d.limit = wdata[TEMP_W-1:0];
            if (hit_slope) cfg_d.slope = wdata[SLOPE_W-1:0];
            if (hit_ctrl)  cfg_d.en    = wdata[EN_BIT];
        end
        if (hit_lock && wdata[LOCK_BIT]) cfg_d.lock = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q.limit <= LIMIT_RST;
            cfg_q.slope <= SLOPE_RST;
            cfg_q.en    <= 1'b0;
            cfg_q.lock  <= 1'b0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign cfg = cfg_q;
endmodule

// File: rtl/thermguard_detect.sv
module thermguard_detect
    import thermguard_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TEMP_W-1:0] celsius,
    input  cfg_t              cfg,
    output logic [TEMP_W-1:0] temp,
    output logic              shut
);
    det_t det_d, det_q;
    logic hot;

    always_comb begin
        hot        = cfg.en && (det_q.temp > cfg.limit);
        det_d.temp = celsius;
        det_d.shut = det_q.shut | hot;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            det_q <= '0;
        end else begin
            det_q <= det_d;
        end
    end

    assign temp = det_q.temp;
    assign shut = det_q.shut;
endmodule

// File: rtl/thermguard.sv
module thermguard
    import thermguard_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 32,
    parameter int RAW_W  = 10,
    parameter int FRAC_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [RAW_W-1:0]  sensor_raw,
    output logic              shutdown_req
);
    cfg_t              cfg;
    logic [TEMP_W-1:0] celsius;
    logic [TEMP_W-1:0] temp;

    thermguard_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .addr  (bus_addr),
        .wr    (bus_wr),
        .wdata (bus_wdata),
        .cfg   (cfg)
    );

    thermguard_calib #(.RAW_W(RAW_W), .SLOPE_W(SLOPE_W), .FRAC_W(FRAC_W), .OUT_W(TEMP_W)) u_calib (
        .raw     (sensor_raw),
        .slope   (cfg.slope),
        .celsius (celsius)
    );

    thermguard_detect u_detect (
        .clk     (clk),
        .rst_n   (rst_n),
        .celsius (celsius),
        .cfg     (cfg),
        .temp    (temp),
        .shut    (shutdown_req)
    );

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            ADDR_W'(ADR_LIMIT): bus_rdata[TEMP_W-1:0]  = cfg.limit;
            ADDR_W'(ADR_SLOPE): bus_rdata[SLOPE_W-1:0] = cfg.slope;
            ADDR_W'(ADR_CTRL):  bus_rdata[EN_BIT]      = cfg.en;
            ADDR_W'(ADR_LOCK):  bus_rdata[LOCK_BIT]    = cfg.lock;
            ADDR_W'(ADR_TEMP):  bus_rdata[TEMP_W-1:0]  = temp;
            default:            bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/thermguard_chk.sv
module thermguard_chk
    import thermguard_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              lock,
    input logic [TEMP_W-1:0] limit,
    input logic [SLOPE_W-1:0] slope,
    input logic              en,
    input logic [TEMP_W-1:0] temp,
    input logic              shutdown_req,
    input logic [3:0]        bus_addr,
    input logic [31:0]       bus_rdata
);
    AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n) lock |=> lock); // R3
    AST_LIMIT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n) lock |=> $stable(limit)); // R7
    AST_SLOPE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n) lock |=> $stable(slope)); // R7
    AST_EN_FROZEN: assert property (@(posedge clk) disable iff (!rst_n) lock |=> $stable(en)); // R7
    AST_SHUT_STICKY: assert property (@(posedge clk) disable iff (!rst_n) shutdown_req |=> shutdown_req); // R9
    AST_SHUT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n) $rose(shutdown_req) |-> $past(en && (temp > limit))); // R8
    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n) (bus_addr > 4'd4) |-> (bus_rdata == 32'd0)); // R12
    AST_LIMIT_RESERVED: assert property (@(posedge clk) disable iff (!rst_n) (bus_addr == 4'd0) |-> (bus_rdata[31:8] == 24'd0)); // R6
endmodule

bind thermguard thermguard_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .lock         (cfg.lock),
    .limit        (cfg.limit),
    .slope        (cfg.slope),
    .en           (cfg.en),
    .temp         (temp),
    .shutdown_req (shutdown_req),
    .bus_addr     (bus_addr),
    .bus_rdata    (bus_rdata)
);

// File: tb/thermguard_tb.sv
`timescale 1ns/1ps
module thermguard_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [9:0]  sensor_raw = '0;
    logic        shutdown_req;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 1'b0;

    logic [7:0]  m_limit;
    logic [31:0] m_slope;
    logic        m_en, m_lock, m_shut;
    logic [7:0]  m_temp;

    always #2 clk = ~clk;

    thermguard u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sensor_raw(sensor_raw),
        .shutdown_req(shutdown_req)
    );

    function automatic logic [7:0] calc(input logic [9:0] r, input logic [31:0] s);
        longint unsigned p;
        p = (longint'(r) * longint'(s)) >> 4;
        return (p > 255) ? 8'd255 : p[7:0];
    endfunction

    function automatic logic [31:0] model_read(input logic [3:0] a);
        case (a)
            4'd0: return {24'd0, m_limit};
            4'd1: return m_slope;
            4'd2: return {30'd0, m_en, 1'b0};
            4'd3: return {31'd0, m_lock};
            4'd4: return {24'd0, m_temp};
            default: return 32'd0;
        endcase
    endfunction

    function automatic string tag_of(input logic [3:0] a);
        case (a)
            4'd0: return "R1";
            4'd1: return "R2";
            4'd2: return "R4";
            4'd3: return "R3";
            4'd4: return "R10";
            default: return "R12";
        endcase
    endfunction

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h (cycle %0d)", tag, got, exp, cyc);
        end
    endtask

    task automatic cycle(input logic [3:0] a, input logic w, input logic [31:0] d,
                         input logic [9:0] r, input string tag);
        logic        n_shut;
        logic [7:0]  n_temp;
        @(negedge clk);
        bus_addr = a; bus_wr = w; bus_wdata = d; sensor_raw = r;
        #1;
        if (!w) chk(tag, bus_rdata, model_read(a));
        chk("R8", {31'd0, shutdown_req}, {31'd0, m_shut});
        @(posedge clk);
        n_shut = m_shut | (m_en && (m_temp > m_limit));
        n_temp = calc(r, m_slope);
        if (w && !m_lock) begin
            if (a == 4'd0) m_limit = d[7:0];
            if (a == 4'd1) m_slope = d;
            if (a == 4'd2) m_en = d[1];
        end
        if (w && a == 4'd3 && d[0]) m_lock = 1'b1;
        m_shut = n_shut;
        m_temp = n_temp;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; bus_wr = 1'b0; sensor_raw = '0;
        repeat (2) @(negedge clk);
        m_limit = 8'd125; m_slope = 32'd25; m_en = 0; m_lock = 0; m_shut = 0; m_temp = 0;
        rst_n = 1'b1;
    endtask

    task automatic random_phase(input int n, input bit allow_lock);
        for (int i = 0; i < n; i++) begin
            logic [3:0]  a;
            logic        w;
            logic [31:0] d;
            a = 4'($urandom_range(0, 7));
            if (!allow_lock && a == 4'd3) a = 4'd0;
            w = ($urandom_range(0, 2) == 0);
            d = ($urandom_range(0, 1) == 0) ? 32'($urandom_range(0, 64)) : $urandom();
            if (a == 4'd0 && w) d = 32'($urandom_range(60, 200));
            cycle(a, w, d, 10'($urandom_range(0, 1023)), tag_of(a));
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            done = 1'b1;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        do_reset();
        // reset values R1 R2 R3 R4 R5
        cycle(4'd0, 0, 0, 0, "R1");
        cycle(4'd1, 0, 0, 0, "R2");
        cycle(4'd2, 0, 0, 0, "R4");
        cycle(4'd3, 0, 0, 0, "R3");
        cycle(4'd4, 0, 0, 0, "R5");
        // R6 reserved bits ignored
        cycle(4'd0, 1, 32'hFFFF_FF40, 0, "R6");
        cycle(4'd0, 0, 0, 0, "R6");
        cycle(4'd2, 1, 32'hFFFF_FFFF, 0, "R6");
        cycle(4'd2, 0, 0, 0, "R6");
        cycle(4'd2, 1, 32'h0, 0, "R4");
        // R10 calibration with default slope, R5 one-cycle latency
        cycle(4'd4, 0, 0, 10'd80, "R5");
        cycle(4'd4, 0, 0, 10'd80, "R10");
        cycle(4'd1, 1, 32'd7, 10'd100, "R10");
        cycle(4'd4, 0, 0, 10'd100, "R10");
        cycle(4'd4, 0, 0, 10'd100, "R10");
        // R11 saturation
        cycle(4'd1, 1, 32'd25, 10'd1023, "R11");
        cycle(4'd4, 0, 0, 10'd1023, "R11");
        cycle(4'd4, 0, 0, 10'd1023, "R11");
        // R12 writes to temp and unmapped addresses
        cycle(4'd4, 1, 32'hAA, 10'd0, "R12");
        cycle(4'd7, 1, 32'hFFFF_FFFF, 10'd0, "R12");
        cycle(4'd7, 0, 0, 0, "R12");
        cycle(4'd15, 0, 0, 0, "R12");
        cycle(4'd0, 0, 0, 0, "R12");
        // R8 boundary: temp == limit does not trip, limit+1 does; R9 sticky
        cycle(4'd0, 1, 32'd100, 10'd64, "R8");
        cycle(4'd2, 1, 32'd2, 10'd64, "R8");
        for (int k = 0; k < 4; k++) cycle(4'd4, 0, 0, 10'd64, "R8");
        cycle(4'd4, 0, 0, 10'd65, "R8");
        cycle(4'd4, 0, 0, 10'd0, "R8");
        cycle(4'd4, 0, 0, 10'd0, "R8");
        cycle(4'd4, 0, 0, 10'd0, "R9");
        cycle(4'd2, 1, 32'd0, 10'd0, "R9");
        for (int k = 0; k < 3; k++) cycle(4'd4, 0, 0, 10'd0, "R9");
        do_reset();
        random_phase(4000, 1'b0);
        do_reset();
        // R3 writing 0 to lock has no effect
        cycle(4'd3, 1, 32'hFFFF_FFFE, 0, "R3");
        cycle(4'd3, 0, 0, 0, "R3");
        cycle(4'd0, 1, 32'd90, 0, "R7");
        cycle(4'd2, 1, 32'd2, 0, "R7");
        cycle(4'd3, 1, 32'd1, 0, "R3");
        cycle(4'd3, 0, 0, 0, "R3");
        // R7 locked writes ignored
        cycle(4'd0, 1, 32'd250, 0, "R7");
        cycle(4'd0, 0, 0, 0, "R7");
        cycle(4'd1, 1, 32'd1, 0, "R7");
        cycle(4'd1, 0, 0, 0, "R7");
        cycle(4'd2, 1, 32'd0, 0, "R7");
        cycle(4'd2, 0, 0, 0, "R7");
        cycle(4'd3, 1, 32'd0, 0, "R3");
        cycle(4'd3, 0, 0, 0, "R3");
        random_phase(3000, 1'b1);
        do_reset();
        cycle(4'd3, 0, 0, 0, "R3");
        cycle(4'd0, 0, 0, 0, "R1");
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule